// File: doc/BRIEF.md
# Delay-Slot Illegal Instruction Checker

This block watches the decode stage of an in-order pipeline whose branches can have a delay slot. It is told when a delayed branch decodes and stores that branch's target in a register. It then classifies the next decoded instruction, which is the one in the delay slot. If that instruction belongs to a class that may not sit in a delay slot, the block raises a one-cycle slot-illegal request in the cycle after decode. With the request it presents the stored branch target as the return PC. An undefined instruction that is not in a delay slot raises a separate general-illegal request instead.

Decoding opcodes into class flags happens upstream. The exception sequence that the requests start happens downstream. Whether the floating-point unit is in module standby changes the classification: while it is, floating-point operations and FPU-related CPU instructions count as undefined code. A pipeline flush closes any open delay-slot window, so a branch that was squashed cannot produce a request.

Top module: `dslot_checker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `slot_illegal`, `gen_illegal` and `ret_pc` are all zero.
- R2: A decode (`dec_valid`=1) inside an open delay-slot window raises `slot_illegal` for exactly the following cycle if any of these `inst_cls` bits is set: bit 0 undefined, bit 1 PC-writing, bit 2 32-bit long, bit 3 register-bank restore, bit 4 signed divide, bit 5 unsigned divide. A slot instruction with none of these bits is legal and raises nothing.
- R3: `inst_cls` bit 6 (floating-point operation) and bit 7 (FPU-related CPU instruction) count as undefined code only while `fpu_standby`=1, both inside and outside a window. With `fpu_standby`=0 they raise no request.
- R4: An undefined decode outside a window raises `gen_illegal` for the following cycle and never `slot_illegal`. Here undefined means bit 0, or bits 6/7 under standby. Bits 1 to 5 outside a window raise nothing. The two requests are never high together.
- R5: A decode with `is_dbr`=1 outside a window opens a window and stores `br_target`. When `slot_illegal` rises, `ret_pc` equals the stored target. `ret_pc` holds its value in every cycle without a slot-illegal request.
- R6: The window stays open through cycles with `dec_valid`=0 and closes on the next valid decode. Only one instruction is classified per window.
- R7: `flush`=1 closes the window and suppresses any request from a decode in the same cycle. A branch that decodes in the same cycle as a flush opens no window.
- R8: `slot_illegal` is a single-cycle pulse. It never stays high for two consecutive cycles.
- R9: A delayed branch (`is_dbr`=1) decoded inside a window is itself slot-illegal. It does not open a new window, so the instruction after it is classified as outside a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush; closes the delay-slot window |
| dec_valid | input | 1 | An instruction is decoded this cycle |
| inst_cls | input | 8 | Class flags of the decoded instruction (bit map in R2, R3) |
| is_dbr | input | 1 | Decoded instruction is a delayed branch |
| br_target | input | ADDR_W | Jump address of the decoded delayed branch |
| fpu_standby | input | 1 | Floating-point unit is in module standby |
| slot_illegal | output | 1 | Slot-illegal request, one cycle after decode |
| gen_illegal | output | 1 | General-illegal request, one cycle after decode |
| ret_pc | output | ADDR_W | Return PC delivered with the slot-illegal request |

## Verification
Directed cases give each forbidden class alone in a slot and compare it against the same class outside a slot. This separates slot-illegal, general-illegal and no request at all. Floating-point classes are tried with standby set and cleared, to show that the reclassification depends only on standby. Idle gaps, flushes on the branch, in the gap and on the slot, and a branch placed in a slot show where the window opens and closes. Long random runs mix all flags with changing standby and targets, and check that `ret_pc` tracks the right branch and holds between requests.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

  localparam int CLS_W = 8;

  localparam int CLS_UNDEF   = 0;
  localparam int CLS_PCWR    = 1;
  localparam int CLS_LONG    = 2;
  localparam int CLS_BANKRST = 3;
  localparam int CLS_DIVS    = 4;
  localparam int CLS_DIVU    = 5;
  localparam int CLS_FPOP    = 6;
  localparam int CLS_FPCPU   = 7;

  typedef logic [CLS_W-1:0] cls_t;

  // classes that are always forbidden in a slot
  localparam cls_t SLOT_BAD_MASK = cls_t'((1 << CLS_UNDEF) | (1 << CLS_PCWR) |
                                          (1 << CLS_LONG)  | (1 << CLS_BANKRST) |
                                          (1 << CLS_DIVS)  | (1 << CLS_DIVU));
  // classes that become undefined while the FPU sleeps
  localparam cls_t FPU_MASK = cls_t'((1 << CLS_FPOP) | (1 << CLS_FPCPU));

  typedef struct packed {
    logic undef_eff;
    logic slot_bad;
  } verdict_t;

endpackage

// File: rtl/dslot_classify.sv
module dslot_classify
  import dslot_pkg::*;
(
  input  cls_t     inst_cls,
  input  logic     is_dbr,
  input  logic     fpu_standby,
  output verdict_t verdict
);

  cls_t fpu_as_undef;
  logic undef_eff;

  always_comb begin
    fpu_as_undef = fpu_standby ? (inst_cls & FPU_MASK) : '0;
    undef_eff    = inst_cls[CLS_UNDEF] | (|fpu_as_undef);
    verdict.undef_eff = undef_eff;
    verdict.slot_bad  = undef_eff | (|(inst_cls & SLOT_BAD_MASK)) | is_dbr;
  end

endmodule

// File: rtl/dslot_window.sv
module dslot_window #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              dec_valid,
  input  logic              is_dbr,
  input  logic [ADDR_W-1:0] br_target,
  output logic              slot_pend,
  output logic [ADDR_W-1:0] slot_tgt
);

  logic open_now;

  assign open_now = dec_valid & is_dbr & ~slot_pend & ~flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_pend <= 1'b0;
    end else if (flush) begin
      slot_pend <= 1'b0;
    end else if (dec_valid) begin
      slot_pend <= open_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_tgt <= '0;
    end else if (open_now) begin
      slot_tgt <= br_target;
    end
  end

endmodule

// File: rtl/dslot_req.sv
module dslot_req
  import dslot_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              dec_valid,
  input  logic              slot_pend,
  input  logic [ADDR_W-1:0] slot_tgt,
  input  verdict_t          verdict,
  output logic              slot_illegal,
  output logic              gen_illegal,
  output logic [ADDR_W-1:0] ret_pc
);

  logic live;
  logic fire_slot;
  logic fire_gen;

  assign live      = dec_valid & ~flush;
  assign fire_slot = live & slot_pend & verdict.slot_bad;
  assign fire_gen  = live & ~slot_pend & verdict.undef_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_illegal <= 1'b0;
      gen_illegal  <= 1'b0;
      ret_pc       <= '0;
    end else begin
      slot_illegal <= fire_slot;
      gen_illegal  <= fire_gen;
      if (fire_slot) begin
        ret_pc <= slot_tgt;
      end
    end
  end

endmodule

// File: rtl/dslot_checker.sv
module dslot_checker
  import dslot_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              dec_valid,
  input  logic [CLS_W-1:0]  inst_cls,
  input  logic              is_dbr,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              fpu_standby,
  output logic              slot_illegal,
  output logic              gen_illegal,
  output logic [ADDR_W-1:0] ret_pc
);

  verdict_t          verdict;
  logic              slot_pend;
  logic [ADDR_W-1:0] slot_tgt;

  dslot_classify u_classify (
    .inst_cls    (inst_cls),
    .is_dbr      (is_dbr),
    .fpu_standby (fpu_standby),
    .verdict     (verdict)
  );

  dslot_window #(.ADDR_W(ADDR_W)) u_window (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .dec_valid (dec_valid),
    .is_dbr    (is_dbr),
    .br_target (br_target),
    .slot_pend (slot_pend),
    .slot_tgt  (slot_tgt)
  );

  dslot_req #(.ADDR_W(ADDR_W)) u_req (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .dec_valid    (dec_valid),
    .slot_pend    (slot_pend),
    .slot_tgt     (slot_tgt),
    .verdict      (verdict),
    .slot_illegal (slot_illegal),
    .gen_illegal  (gen_illegal),
    .ret_pc       (ret_pc)
  );

endmodule

// File: rtl/dslot_checker_sva.sv
module dslot_checker_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              dec_valid,
  input logic [7:0]        inst_cls,
  input logic              is_dbr,
  input logic              fpu_standby,
  input logic              slot_pend,
  input logic [ADDR_W-1:0] slot_tgt,
  input logic              slot_illegal,
  input logic              gen_illegal,
  input logic [ADDR_W-1:0] ret_pc
);

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    slot_illegal |=> !slot_illegal);

  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(slot_illegal && gen_illegal));

  p_in_window_r2: assert property (@(posedge clk) disable iff (rst)
    slot_illegal |-> $past(slot_pend && dec_valid));

  p_gen_outside_r4: assert property (@(posedge clk) disable iff (rst)
    gen_illegal |-> !$past(slot_pend));

  p_retpc_r5: assert property (@(posedge clk) disable iff (rst)
    slot_illegal |-> ret_pc == $past(slot_tgt));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !slot_illegal |-> $stable(ret_pc));

  p_flush_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !slot_illegal && !gen_illegal);

  p_flush_close_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !slot_pend);

  p_fpu_awake_r3: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !fpu_standby && !is_dbr && (inst_cls & 8'h3F) == 8'h00)
      |=> !slot_illegal && !gen_illegal);

endmodule

bind dslot_checker dslot_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .flush        (flush),
  .dec_valid    (dec_valid),
  .inst_cls     (inst_cls),
  .is_dbr       (is_dbr),
  .fpu_standby  (fpu_standby),
  .slot_pend    (slot_pend),
  .slot_tgt     (slot_tgt),
  .slot_illegal (slot_illegal),
  .gen_illegal  (gen_illegal),
  .ret_pc       (ret_pc)
);

// File: tb/test_dslot_checker.sv
module test_dslot_checker;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic              flush;
  logic              dec_valid;
  logic [7:0]        inst_cls;
  logic              is_dbr;
  logic [ADDR_W-1:0] br_target;
  logic              fpu_standby;
  logic              slot_illegal;
  logic              gen_illegal;
  logic [ADDR_W-1:0] ret_pc;

  int n_chk  = 0;
  int n_fail = 0;

  // reference state
  bit              m_pend;
  bit [ADDR_W-1:0] m_tgt;
  bit [ADDR_W-1:0] m_ret;

  always #(CLK_P/2) clk = ~clk;

  dslot_checker #(.ADDR_W(ADDR_W)) i_dslot_checker (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .dec_valid    (dec_valid),
    .inst_cls     (inst_cls),
    .is_dbr       (is_dbr),
    .br_target    (br_target),
    .fpu_standby  (fpu_standby),
    .slot_illegal (slot_illegal),
    .gen_illegal  (gen_illegal),
    .ret_pc       (ret_pc)
  );

  function automatic bit f_undef(input bit [7:0] c, input bit stby);
    return c[0] | (stby & (c[6] | c[7]));
  endfunction

  function automatic bit f_slot_bad(input bit [7:0] c, input bit dbr, input bit stby);
    return f_undef(c, stby) | (|c[5:1]) | dbr;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive one decode cycle at the falling edge, check after the next rising edge
  task automatic step(input string tag, input bit dv, input bit [7:0] c, input bit dbr,
                      input bit [ADDR_W-1:0] tgt, input bit stby, input bit fl);
    bit e_slot, e_gen;
    dec_valid = dv; inst_cls = c; is_dbr = dbr;
    br_target = tgt; fpu_standby = stby; flush = fl;
    e_slot = dv & ~fl & m_pend & f_slot_bad(c, dbr, stby);
    e_gen  = dv & ~fl & ~m_pend & f_undef(c, stby);
    if (e_slot) m_ret = m_tgt;
    if (fl) m_pend = 1'b0;
    else if (dv) begin
      if (dbr && !m_pend) begin
        m_pend = 1'b1;
        m_tgt  = tgt;
      end else m_pend = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "slot_illegal", ADDR_W'(slot_illegal), ADDR_W'(e_slot));
    check(tag, "gen_illegal",  ADDR_W'(gen_illegal),  ADDR_W'(e_gen));
    check(tag, "ret_pc",       ret_pc, m_ret);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 8'h00, 1'b0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; flush = 1'b0; dec_valid = 1'b0; inst_cls = '0;
    is_dbr = 1'b0; br_target = '0; fpu_standby = 1'b0;
    m_pend = 0; m_tgt = '0; m_ret = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset
    check("R1", "slot_illegal", ADDR_W'(slot_illegal), '0);
    check("R1", "gen_illegal",  ADDR_W'(gen_illegal),  '0);
    check("R1", "ret_pc",       ret_pc, '0);
    rst = 1'b0;
    idle("R1", 1);

    // R2 each always-forbidden class in a slot
    for (int b = 0; b < 6; b++) begin
      step("R2", 1, 8'h00, 1, 32'h1000 + 32'(b * 16), 0, 0);
      step("R2", 1, 8'(1 << b), 0, '0, 0, 0);
      idle("R8", 1);
    end
    // R2 legal slot instruction
    step("R2", 1, 8'h00, 1, 32'hAAAA_0000, 0, 0);
    step("R2", 1, 8'h00, 0, '0, 0, 0);
    // R4 same classes outside a slot
    for (int b = 0; b < 6; b++) step("R4", 1, 8'(1 << b), 0, '0, 0, 0);
    // R3 floating-point classes, awake and asleep, in and out of a slot
    for (int s = 0; s < 2; s++) begin
      for (int b = 6; b < 8; b++) begin
        step("R3", 1, 8'h00, 1, 32'h2000 + 32'(b), s[0], 0);
        step("R3", 1, 8'(1 << b), 0, '0, s[0], 0);
        step("R3", 1, 8'(1 << b), 0, '0, s[0], 0);
      end
    end
    // R6 idle gap keeps the window open
    step("R6", 1, 8'h00, 1, 32'hBEEF_0010, 0, 0);
    idle("R6", 3);
    step("R6", 1, 8'h04, 0, '0, 0, 0);
    step("R6", 1, 8'h04, 0, '0, 0, 0);
    idle("R5", 2);
    // R7 flush on the branch, in the gap, and on the slot
    step("R7", 1, 8'h00, 1, 32'hC0DE_0000, 0, 1);
    step("R7", 1, 8'h01, 0, '0, 0, 0);
    step("R7", 1, 8'h00, 1, 32'hC0DE_0100, 0, 0);
    step("R7", 0, 8'h00, 0, '0, 0, 1);
    step("R7", 1, 8'h01, 0, '0, 0, 0);
    step("R7", 1, 8'h00, 1, 32'hC0DE_0200, 0, 0);
    step("R7", 1, 8'h10, 0, '0, 0, 1);
    // R9 branch in a slot
    step("R9", 1, 8'h00, 1, 32'hD000_0000, 0, 0);
    step("R9", 1, 8'h00, 1, 32'hD000_0400, 0, 0);
    step("R9", 1, 8'h20, 0, '0, 0, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] c;
      bit stby;
      c = '0;
      for (int b = 0; b < 8; b++) c[b] = ($urandom % 7) == 0;
      stby = ((i / 40) % 2) == 1;
      step(((i % 2) == 0) ? "R5" : "R2", ($urandom % 4) != 0, c, ($urandom % 3) == 0,
           $urandom, stby, ($urandom % 16) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule